// File: doc/BRIEF.md
# Serial Receive Channel with Latched Error Status

This block takes an asynchronous serial line, recovers 8-bit frames from it, and stores each good byte in a single receive buffer. An optional parity bit can follow the data. A host reaches the channel through a small register port. Through it the host sets the power and receive-enable bits, the parity mode and the baud divisor. It then reads the error status and the received byte. Errors stay latched until the byte is taken. A frame that arrives while the buffer is still full is dropped, and the byte already stored is kept.

The baud timebase is a 5-bit programmable counter followed by a divide-by-two stage. This yields one oversampling tick every 2·D clocks, and sixteen ticks make one bit. Bring-up order matters: power goes on first and the enable after it. The divisor may only change while reception is disabled.

Top module: `uart_rx_errlatch`

## Requirements
- R1: With divisor D (a value of 0 acts as 1), one oversampling tick occurs every 2·D clocks and one bit lasts 32·D clocks. Frames sent at this rate are received correctly for D=2 and D=3.
- R2: The start bit is confirmed by a sample at mid-bit. A low pulse shorter than half a bit returns the receiver to idle with no interrupt and no status change. Data is 8 bits, LSB first, each bit sampled mid-bit.
- R3: Parity mode is bits [3:2] of CTRL (address 0). 00 means no parity bit. 01 means a parity bit is present but never checked. 10 means even parity and 11 means odd parity. A parity error (STAT bit 0) is raised only in modes 10 and 11 when the parity check fails.
- R4: Only the first stop bit is checked. If it is sampled low, the framing error bit (STAT bit 1) is set. The two-stop bit (CTRL bit 4) has no effect on reception, so a new start bit may follow a single stop bit directly.
- R5: If a frame completes while the buffer-full flag (STAT bit 3) is 1, the overrun bit (STAT bit 2) is set, the new byte is discarded and the buffer keeps its old value.
- R6: Error bits accumulate and persist until the buffer (address 3) is read. Such a read clears STAT bits 0 to 3. A frame that completes while the previous byte, taken in with an error, is still unread causes an overrun, and the earlier error bit stays set.
- R7: rx_irq pulses for one clock when a frame is stored with no error. err_irq pulses for one clock when any error bit goes from 0 to 1. The two never pulse together.
- R8: Writes to DIV (address 1, bits [4:0]) are ignored while receive-enable (CTRL bit 1) is 1.
- R9: Receive-enable can only be set while power (CTRL bit 0) is already 1. A write that clears power also clears receive-enable, resets the receiver, and clears all STAT bits.
- R10: After reset, all four registers read 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 CTRL, 1 DIV, 2 STAT, 3 DATA |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; a read of address 3 clears the status |
| rd_data | output | 8 | Register read data (combinational from addr) |
| rx_irq | output | 1 | Good-frame pulse |
| err_irq | output | 1 | New-error pulse |

## Verification
The bench sends frames back to back with only one stop bit while two-stop mode is set. A receiver that demanded a second stop bit would flag a framing error or lose the second byte. It sends a frame into a full buffer and checks that the old byte survives. It also checks that a second overrun raises no further interrupt. A design that overwrote the buffer, or re-pulsed on bits already set, would fail these checks. Short start glitches, parity modes that must not check, and a divisor write made while reception is enabled are each checked. A receiver that started on any edge would report spurious frames. A design that checked the fixed-parity mode would report false errors. A design that accepted the divisor write would lose bit timing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int REG_W = 8;
  localparam int OVS   = 16;
  localparam int OVS_W = $clog2(OVS);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } frame_st_t;
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sub_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;
  logic             half_q, half_d, wrap;

  always_comb begin
    div_eff = (div == '0) ? DIV_W'(1) : div;
    wrap    = (cnt_q == div_eff - DIV_W'(1));
    cnt_d   = cnt_q;
    half_d  = half_q;
    if (!en) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      half_d = ~half_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  assign sub_tick = en & wrap & half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sub_tick,
  input  logic              rxd_s,
  input  logic [1:0]        par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int BIT_W = $clog2(DATA_W + 1);

  frame_st_t         st_q, st_d;
  logic [OVS_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              done_q, done_d, perr_q, perr_d, ferr_q, ferr_d;
  logic              mid;

  assign mid = sub_tick && (cnt_q == OVS_W'(OVS - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    par_d  = par_q;
    done_d = 1'b0;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (sub_tick) cnt_d = cnt_q + OVS_W'(1);
    if (!en) begin
      st_d  = FS_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        FS_IDLE: begin
          cnt_d = '0;
          if (!rxd_s) st_d = FS_START;
        end
        FS_START: begin
          if (sub_tick && cnt_q == OVS_W'(OVS / 2 - 1)) begin
            cnt_d = '0;
            bit_d = '0;
            st_d  = rxd_s ? FS_IDLE : FS_DATA;
          end
        end
        FS_DATA: begin
          if (mid) begin
            sh_d  = {rxd_s, sh_q[DATA_W-1:1]};
            bit_d = bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(DATA_W - 1))
              st_d = (par_mode == 2'b00) ? FS_STOP : FS_PAR;
          end
        end
        FS_PAR: begin
          if (mid) begin
            par_d = rxd_s;
            st_d  = FS_STOP;
          end
        end
        FS_STOP: begin
          if (mid) begin
            done_d = 1'b1;
            ferr_d = ~rxd_s;
            perr_d = par_mode[1] & (^sh_q ^ par_q ^ par_mode[0]);
            st_d   = FS_IDLE;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      done_q <= done_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign perr = perr_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              fr_done,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_perr,
  input  logic              fr_ferr,
  output logic [REG_W-1:0]  rd_data,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              pwr,
  output logic              rxen,
  output logic [1:0]        par_mode,
  output logic [DIV_W-1:0]  div,
  output logic              full,
  output logic [2:0]        err,
  output logic [DATA_W-1:0] rbuf
);
  logic              pwr_q, pwr_d, rxen_q, rxen_d, two_q, two_d;
  logic [1:0]        pm_q, pm_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [2:0]        err_q, err_d, err_base, err_set;
  logic              full_q, full_d, full_base;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              rxi_q, rxi_d, eri_q, eri_d;
  logic              wr_ctl, wr_div, rd_buf;

  always_comb begin
    wr_ctl    = wr_en && (addr == A_CTRL);
    wr_div    = wr_en && (addr == A_DIV);
    rd_buf    = rd_en && (addr == A_DATA);
    pwr_d     = wr_ctl ? wr_data[0] : pwr_q;
    rxen_d    = wr_ctl ? (wr_data[1] & wr_data[0] & pwr_q) : rxen_q;
    pm_d      = wr_ctl ? wr_data[3:2] : pm_q;
    two_d     = wr_ctl ? wr_data[4] : two_q;
    div_d     = (wr_div && !rxen_q) ? wr_data[DIV_W-1:0] : div_q;
    full_base = rd_buf ? 1'b0 : full_q;
    err_base  = rd_buf ? 3'b000 : err_q;
    err_set   = 3'b000;
    buf_d     = buf_q;
    full_d    = full_base;
    rxi_d     = 1'b0;
    if (fr_done) begin
      if (full_base) begin
        err_set[2] = 1'b1;
      end else begin
        buf_d      = fr_data;
        full_d     = 1'b1;
        err_set[0] = fr_perr;
        err_set[1] = fr_ferr;
        rxi_d      = ~fr_perr & ~fr_ferr;
      end
    end
    err_d = err_base | err_set;
    eri_d = |(err_set & ~err_base);
    if (!pwr_d) begin
      err_d  = 3'b000;
      full_d = 1'b0;
      rxi_d  = 1'b0;
      eri_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      rxen_q <= 1'b0;
      pm_q   <= 2'b00;
      two_q  <= 1'b0;
      div_q  <= '0;
      err_q  <= 3'b000;
      full_q <= 1'b0;
      buf_q  <= '0;
      rxi_q  <= 1'b0;
      eri_q  <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      rxen_q <= rxen_d;
      pm_q   <= pm_d;
      two_q  <= two_d;
      div_q  <= div_d;
      err_q  <= err_d;
      full_q <= full_d;
      buf_q  <= buf_d;
      rxi_q  <= rxi_d;
      eri_q  <= eri_d;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = REG_W'({two_q, pm_q, rxen_q, pwr_q});
      A_DIV:   rd_data = REG_W'(div_q);
      A_STAT:  rd_data = REG_W'({full_q, err_q});
      default: rd_data = REG_W'(buf_q);
    endcase
  end

  assign rx_irq   = rxi_q;
  assign err_irq  = eri_q;
  assign pwr      = pwr_q;
  assign rxen     = rxen_q;
  assign par_mode = pm_q;
  assign div      = div_q;
  assign full     = full_q;
  assign err      = err_q;
  assign rbuf     = buf_q;
endmodule

// File: rtl/uart_rx_errlatch.sv
module uart_rx_errlatch
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rx_irq,
  output logic       err_irq
);
  logic [1:0]        rst_sync_q, rxd_sync_q;
  logic              srst_n;
  logic              ctl_pwr, ctl_rxen, sub_tick;
  logic [1:0]        ctl_pm;
  logic [DIV_W-1:0]  ctl_div;
  logic              fr_done, fr_perr, fr_ferr, st_full;
  logic [DATA_W-1:0] fr_data, rbuf;
  logic [2:0]        st_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rxd_sync_q <= 2'b11;
    else         rxd_sync_q <= {rxd_sync_q[0], rxd};
  end

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(srst_n), .en(ctl_rxen), .div(ctl_div), .sub_tick(sub_tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(srst_n), .en(ctl_rxen), .sub_tick(sub_tick),
    .rxd_s(rxd_sync_q[1]), .par_mode(ctl_pm), .done(fr_done), .data(fr_data),
    .perr(fr_perr), .ferr(fr_ferr)
  );

  uart_rx_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .fr_done(fr_done), .fr_data(fr_data), .fr_perr(fr_perr),
    .fr_ferr(fr_ferr), .rd_data(rd_data), .rx_irq(rx_irq), .err_irq(err_irq),
    .pwr(ctl_pwr), .rxen(ctl_rxen), .par_mode(ctl_pm), .div(ctl_div),
    .full(st_full), .err(st_err), .rbuf(rbuf)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input logic              clk,
  input logic              srst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        addr,
  input logic              rx_irq,
  input logic              err_irq,
  input logic              pwr,
  input logic              rxen,
  input logic [DIV_W-1:0]  div,
  input logic              full,
  input logic [2:0]        err,
  input logic [DATA_W-1:0] rbuf,
  input logic              fr_done
);
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!srst_n)
    !(rx_irq && err_irq)); // R7
  AST_RXIRQ_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    rx_irq |=> !rx_irq); // R7
  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (!srst_n)
    rxen |=> $stable(div)); // R8
  AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!srst_n)
    rxen |-> pwr); // R9
  AST_PWR_OFF_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    !pwr |-> (err == 3'b000 && !full)); // R9
  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!srst_n)
    (fr_done && full && pwr && !wr_en && !(rd_en && addr == 2'd3))
      |=> ($stable(rbuf) && full && err[2])); // R5
endmodule

bind uart_rx_errlatch uart_rx_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rx_irq(rx_irq), .err_irq(err_irq), .pwr(ctl_pwr), .rxen(ctl_rxen),
  .div(ctl_div), .full(st_full), .err(st_err), .rbuf(rbuf), .fr_done(fr_done)
);

// File: tb/sim_uart_rx_errlatch.sv
`timescale 1ns/1ps
module sim_uart_rx_errlatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_irq, err_irq;

  int checks = 0;
  int failures = 0;
  int n_rx = 0;
  int n_err = 0;
  int bit_clks = 64;

  always #2 clk = ~clk;

  uart_rx_errlatch u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always @(negedge clk) begin
    if (rx_irq)  n_rx++;
    if (err_irq) n_err++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input bit has_par, input bit pbit, input bit stop_ok);
    rxd = 1'b0; clks(bit_clks);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; clks(bit_clks); end
    if (has_par) begin rxd = pbit; clks(bit_clks); end
    if (stop_ok) begin
      rxd = 1'b1; clks(bit_clks);
    end else begin
      rxd = 1'b0; clks(bit_clks * 5 / 8);
      rxd = 1'b1; clks(bit_clks);
    end
    clks(4);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R10 reg after reset", v, 0);
    end
    chk("R10 irq low", {rx_irq, err_irq}, 0);
  endtask

  task automatic t_enable_order();
    logic [7:0] v;
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R9 enable without power ignored", v, 8'h00);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R8 divisor write while disabled", v, 8'h02);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    rd(2'd0, v); chk("R9 enable after power", v, 8'h03);
    wr(2'd1, 8'h05);
    rd(2'd1, v); chk("R8 divisor write while enabled ignored", v, 8'h02);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    int r0;
    r0 = n_rx;
    send(8'hA5, 0, 0, 1);
    chk("R7 rx_irq on good frame", n_rx - r0, 1);
    rd(2'd2, v); chk("R2 status full only", v, 8'h08);
    rd(2'd3, v); chk("R2 data LSB first", v, 8'hA5);
    rd(2'd2, v); chk("R6 status cleared by data read", v, 8'h00);
    send(8'h3C, 0, 0, 1);
    rd(2'd2, v); rd(2'd3, v); chk("R1 second byte at D=2", v, 8'h3C);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    int r0, e0;
    r0 = n_rx; e0 = n_err;
    rxd = 1'b0; clks(10); rxd = 1'b1; clks(bit_clks * 12);
    chk("R2 glitch no irq", (n_rx - r0) + (n_err - e0), 0);
    rd(2'd2, v); chk("R2 glitch no status", v, 8'h00);
    send(8'h5A, 0, 0, 1);
    rd(2'd2, v); rd(2'd3, v); chk("R2 frame after glitch", v, 8'h5A);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    int e0;
    wr(2'd0, 8'h0B);
    send(8'h07, 1, 1, 1);
    rd(2'd2, v); chk("R3 even parity good", v, 8'h08);
    rd(2'd3, v); chk("R3 even parity data", v, 8'h07);
    e0 = n_err;
    send(8'h07, 1, 0, 1);
    rd(2'd2, v); chk("R3 even parity error", v, 8'h09);
    chk("R7 err_irq on parity error", n_err - e0, 1);
    send(8'h55, 1, 0, 1);
    rd(2'd2, v); chk("R6 error kept plus overrun", v, 8'h0D);
    rd(2'd3, v); chk("R6 first byte kept", v, 8'h07);
    wr(2'd0, 8'h0F);
    send(8'h07, 1, 0, 1);
    rd(2'd2, v); chk("R3 odd parity good", v, 8'h08);
    rd(2'd3, v);
    wr(2'd0, 8'h07);
    send(8'hC3, 1, 1, 1);
    rd(2'd2, v); chk("R3 fixed parity not checked", v, 8'h08);
    rd(2'd3, v); chk("R3 fixed parity data", v, 8'hC3);
  endtask

  task automatic t_stop();
    logic [7:0] v, s1, d1;
    wr(2'd0, 8'h13);
    fork
      begin send(8'h11, 0, 0, 1); send(8'h22, 0, 0, 1); end
      begin @(posedge rx_irq); rd(2'd2, s1); rd(2'd3, d1); end
    join
    chk("R4 first frame status", s1, 8'h08);
    chk("R4 first frame data", d1, 8'h11);
    rd(2'd2, v); chk("R4 single stop accepted in two-stop mode", v, 8'h08);
    rd(2'd3, v); chk("R4 back-to-back data", v, 8'h22);
    send(8'h66, 0, 0, 0);
    rd(2'd2, v); chk("R4 framing error", v, 8'h0A);
    rd(2'd3, v);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    int e0;
    wr(2'd0, 8'h03);
    send(8'h11, 0, 0, 1);
    e0 = n_err;
    send(8'h22, 0, 0, 1);
    rd(2'd2, v); chk("R5 overrun flagged", v, 8'h0C);
    chk("R7 err_irq on overrun", n_err - e0, 1);
    send(8'h33, 0, 0, 1);
    chk("R7 no err_irq for already set bit", n_err - e0, 1);
    rd(2'd3, v); chk("R5 old byte kept", v, 8'h11);
    rd(2'd2, v); chk("R6 cleared after read", v, 8'h00);
  endtask

  task automatic t_power();
    logic [7:0] v;
    send(8'h44, 0, 0, 1);
    send(8'h45, 0, 0, 1);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk("R9 power off clears status", v, 8'h00);
    rd(2'd0, v); chk("R9 power off clears enable", v, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    bit_clks = 96;
    send(8'h96, 0, 0, 1);
    rd(2'd2, v); rd(2'd3, v); chk("R1 frame at D=3", v, 8'h96);
  endtask

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(4);
    t_reset();
    t_enable_order();
    t_basic();
    t_glitch();
    t_parity();
    t_stop();
    t_overrun();
    t_power();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule